// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block sits on the host side of an asynchronous NOR flash command bus and carries out block erases on request. The host raises a start request together with a block number and two qualifiers: one marks the request as the last of a series, the other asks for the full status check after every block. The sequencer then writes the two-cycle erase command to the block, reads the device status register repeatedly until the device reports ready, and returns a single result code with a one-cycle acknowledge.

When a status check is due, the error bits of the final status byte are decoded in a fixed priority order. An error causes a clear-status command to be written, and every checked block ends with a write that returns the device to read-array mode. An unchecked block inside a series skips the decode and both closing writes, so that the device's sticky error bits can be checked once at the end of the series. A programmable poll limit ends an erase that never reports ready.

The host holds the block number, the last-block flag and the check-each flag stable from the request until the acknowledge, and it drops the request after the acknowledge.

Top module: `flash_erase_seq`

## Requirements
- R1: The first bus write of every erase carries data 0x20 at address {block, OFF_W zero bits}.
- R2: The second bus write carries data 0xD0 at the same address as the first.
- R3: Every bus write holds weN low for exactly WE_CYCLES clocks with ceN low and oeN high, and drives flAddr and dqOut with dqOe high, unchanged, from one clock before weN falls until one clock after it rises.
- R4: Each status read holds ceN and oeN low for READ_CYCLES clocks, both return high for at least one clock before the next read, and polling stops at the first status byte whose bit 7 is 1.
- R5: On a checked block the ready status byte is decoded in priority order: bit 3 set gives code 1; else bits 4 and 5 both set give code 2; else bit 5 set gives code 3; else bit 1 set gives code 4; otherwise code 0.
- R6: When the decoded code is 1 to 4, the sequencer writes 0x50 before the closing 0xFF write; with code 0 no 0x50 is written.
- R7: A block is checked when checkEach or lastBlock is 1; a checked block ends with a 0xFF write and then the acknowledge.
- R8: A block with checkEach and lastBlock both 0 performs only the 0x20 and 0xD0 writes and its polling, and returns code 6.
- R9: When pollLimit consecutive status reads all show bit 7 at 0, polling stops after exactly pollLimit reads, only a 0xFF write follows (no 0x50), and the code is 5.
- R10: During and straight after reset ceN, oeN and weN are 1, dqOe is 0 and startAck is 0.
- R11: startAck is high for exactly one clock per request, with resultCode valid in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Host request to erase a block |
| blockAddr | input | BLK_W | Block number to erase |
| lastBlock | input | 1 | Request is the last of a series |
| checkEach | input | 1 | Run the status check after every block |
| pollLimit | input | CNT_W | Number of busy status reads before timeout |
| startAck | output | 1 | One-cycle completion pulse |
| resultCode | output | 3 | Result code, valid with startAck |
| ceN | output | 1 | Device chip enable, active low |
| oeN | output | 1 | Device output enable, active low |
| weN | output | 1 | Device write enable, active low |
| flAddr | output | BLK_W+OFF_W | Device address |
| dqOut | output | 8 | Data driven to the device |
| dqOe | output | 1 | Drive enable for dqOut |
| dqIn | input | 8 | Data read from the device |

## Verification
A behavioural flash model answers each status read with busy or ready and accumulates error bits across erases until a 0x50 write clears them. The table walk uses single error bits, pairs of bits that test the decode priority (bits 3 and 1, bits 5 and 1), bit 4 alone which must not count as an error, and different busy lengths, so the written command list and the read count separate a correct priority order and poll exit from an off-by-one or wrong ordering. Directed runs cover a two-block series where the first block's error surfaces only in the final check, a device that never becomes ready, and the idle bus state at reset.

// File: rtl/erase_pkg.sv
package erase_pkg;

  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_VOLT    = 3'd1,
    RES_SEQ     = 3'd2,
    RES_ERASE   = 3'd3,
    RES_LOCKED  = 3'd4,
    RES_TIMEOUT = 3'd5,
    RES_DEFER   = 3'd6
  } result_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] data;
  } bus_cmd_t;

  function automatic result_t decodeStatus(input logic [7:0] sr);
    if (sr[3])               return RES_VOLT;
    else if (sr[4] && sr[5]) return RES_SEQ;
    else if (sr[5])          return RES_ERASE;
    else if (sr[1])          return RES_LOCKED;
    else                     return RES_OK;
  endfunction

endpackage

// File: rtl/erase_dpath.sv
module erase_dpath
  import erase_pkg::*;
#(
  parameter int BLK_W       = 4,
  parameter int OFF_W       = 12,
  parameter int WE_CYCLES   = 3,
  parameter int READ_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  bus_cmd_t         busCmd,
  input  logic [BLK_W-1:0] blockAddr,
  input  logic [7:0]       dqIn,
  output logic             busDone,
  output logic [7:0]       statusByte,
  output logic             ceN,
  output logic             oeN,
  output logic             weN,
  output logic [BLK_W+OFF_W-1:0] flAddr,
  output logic [7:0]       dqOut,
  output logic             dqOe
);

  localparam int MAX_CYC  = (WE_CYCLES > READ_CYCLES) ? WE_CYCLES : READ_CYCLES;
  localparam int CNT_BITS = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {D_IDLE, D_WSET, D_WLOW, D_WHOLD, D_RACT, D_RGAP} dstate_t;

  dstate_t             state;
  logic [CNT_BITS-1:0] cnt;
  logic [BLK_W-1:0]    addrReg;
  logic [7:0]          dataReg;
  logic                busFree;

  assign busDone = (state == D_WHOLD) || (state == D_RGAP);
  assign busFree = busDone || (state == D_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= D_IDLE;
      cnt        <= '0;
      addrReg    <= '0;
      dataReg    <= '0;
      statusByte <= '0;
    end else if (busFree && busCmd.wr) begin
      state   <= D_WSET;
      dataReg <= busCmd.data;
      addrReg <= blockAddr;
    end else if (busFree && busCmd.rd) begin
      state   <= D_RACT;
      cnt     <= CNT_BITS'(READ_CYCLES - 1);
      addrReg <= blockAddr;
    end else if (busDone) begin
      state <= D_IDLE;
    end else begin
      case (state)
        D_WSET: begin
          state <= D_WLOW;
          cnt   <= CNT_BITS'(WE_CYCLES - 1);
        end
        D_WLOW: begin
          if (cnt == '0) state <= D_WHOLD;
          else           cnt   <= cnt - 1'b1;
        end
        D_RACT: begin
          if (cnt == '0) begin
            statusByte <= dqIn;
            state      <= D_RGAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign ceN    = !((state == D_WSET) || (state == D_WLOW) || (state == D_WHOLD) || (state == D_RACT));
  assign weN    = (state != D_WLOW);
  assign oeN    = (state != D_RACT);
  assign dqOe   = (state == D_WSET) || (state == D_WLOW) || (state == D_WHOLD);
  assign flAddr = {addrReg, {OFF_W{1'b0}}};
  assign dqOut  = dataReg;

  // width of the write strobe, counted independently of the state counter
  logic [7:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     weLowCnt <= '0;
    else if (weN)  weLowCnt <= '0;
    else           weLowCnt <= weLowCnt + 1'b1;
  end

  a_r3_we_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> (weLowCnt == 8'(WE_CYCLES)));
  a_r3_setup_stable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> ($stable(flAddr) && $stable(dqOut) && dqOe && $past(dqOe)));
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> ($stable(flAddr) && $stable(dqOut) && dqOe && !ceN));
  a_r3_no_read_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (oeN && !ceN));
  a_r4_toggle_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeN) |-> ceN);

endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import erase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             lastBlock,
  input  logic             checkEach,
  input  logic [CNT_W-1:0] pollLimit,
  input  logic             busDone,
  input  logic [7:0]       statusByte,
  output bus_cmd_t         busCmd,
  output logic             startAck,
  output logic [2:0]       resultCode
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CONF, S_POLL, S_CLR, S_ARR, S_ACK} cstate_t;

  cstate_t          state, stateNxt;
  logic [CNT_W-1:0] pollCnt, pollCntNxt;
  result_t          res, resNxt;
  logic             checked;
  logic             pollExpired;

  assign checked     = checkEach || lastBlock;
  assign pollExpired = ({1'b0, pollCnt} + 1'b1) >= {1'b0, pollLimit};

  always_comb begin
    stateNxt   = state;
    pollCntNxt = pollCnt;
    resNxt     = res;
    busCmd     = '0;
    case (state)
      S_IDLE: if (startReq) begin
        busCmd.wr = 1'b1; busCmd.data = CMD_SETUP; stateNxt = S_SETUP;
      end
      S_SETUP: if (busDone) begin
        busCmd.wr = 1'b1; busCmd.data = CMD_CONFIRM; stateNxt = S_CONF;
      end
      S_CONF: if (busDone) begin
        busCmd.rd = 1'b1; pollCntNxt = '0; stateNxt = S_POLL;
      end
      S_POLL: if (busDone) begin
        if (statusByte[7]) begin
          if (!checked) begin
            resNxt = RES_DEFER; stateNxt = S_ACK;
          end else begin
            resNxt = decodeStatus(statusByte);
            busCmd.wr = 1'b1;
            if (decodeStatus(statusByte) != RES_OK) begin
              busCmd.data = CMD_CLEAR; stateNxt = S_CLR;
            end else begin
              busCmd.data = CMD_ARRAY; stateNxt = S_ARR;
            end
          end
        end else if (pollExpired) begin
          resNxt = RES_TIMEOUT;
          busCmd.wr = 1'b1; busCmd.data = CMD_ARRAY; stateNxt = S_ARR;
        end else begin
          pollCntNxt = pollCnt + 1'b1;
          busCmd.rd  = 1'b1;
        end
      end
      S_CLR: if (busDone) begin
        busCmd.wr = 1'b1; busCmd.data = CMD_ARRAY; stateNxt = S_ARR;
      end
      S_ARR: if (busDone) stateNxt = S_ACK;
      S_ACK: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollCnt <= '0;
      res     <= RES_OK;
    end else begin
      state   <= stateNxt;
      pollCnt <= pollCntNxt;
      res     <= resNxt;
    end
  end

  assign startAck   = (state == S_ACK);
  assign resultCode = res;

  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    startAck |=> !startAck);
  a_r8_defer_only_unchecked: assert property (@(posedge clk) disable iff (!rstN)
    (startAck && (resultCode == RES_DEFER)) |-> !checked);
  a_r6_clear_on_error: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CLR && busDone) |-> (resultCode >= 3'd1 && resultCode <= 3'd4));
  a_r9_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL && pollLimit != '0) |-> (pollCnt < pollLimit));
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(busCmd.wr && busCmd.rd));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import erase_pkg::*;
#(
  parameter int BLK_W       = 4,
  parameter int OFF_W       = 12,
  parameter int WE_CYCLES   = 3,
  parameter int READ_CYCLES = 2,
  parameter int CNT_W       = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [BLK_W-1:0]       blockAddr,
  input  logic                   lastBlock,
  input  logic                   checkEach,
  input  logic [CNT_W-1:0]       pollLimit,
  output logic                   startAck,
  output logic [2:0]             resultCode,
  output logic                   ceN,
  output logic                   oeN,
  output logic                   weN,
  output logic [BLK_W+OFF_W-1:0] flAddr,
  output logic [7:0]             dqOut,
  output logic                   dqOe,
  input  logic [7:0]             dqIn
);

  bus_cmd_t   busCmd;
  logic       busDone;
  logic [7:0] statusByte;

  erase_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lastBlock(lastBlock),
    .checkEach(checkEach), .pollLimit(pollLimit), .busDone(busDone),
    .statusByte(statusByte), .busCmd(busCmd), .startAck(startAck),
    .resultCode(resultCode)
  );

  erase_dpath #(.BLK_W(BLK_W), .OFF_W(OFF_W), .WE_CYCLES(WE_CYCLES),
                .READ_CYCLES(READ_CYCLES)) i_dpath (
    .clk(clk), .rstN(rstN), .busCmd(busCmd), .blockAddr(blockAddr),
    .dqIn(dqIn), .busDone(busDone), .statusByte(statusByte), .ceN(ceN),
    .oeN(oeN), .weN(weN), .flAddr(flAddr), .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;

  localparam int BLK_W = 4;
  localparam int OFF_W = 12;
  localparam int WE_CYC = 3;
  localparam int RD_CYC = 2;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [BLK_W-1:0] blockAddr = '0;
  logic lastBlock = 1'b0;
  logic checkEach = 1'b0;
  logic [CNT_W-1:0] pollLimit = 16'd8;
  logic startAck;
  logic [2:0] resultCode;
  logic ceN, oeN, weN, dqOe;
  logic [BLK_W+OFF_W-1:0] flAddr;
  logic [7:0] dqOut;
  logic [7:0] dqIn = 8'h00;

  always #2 clk = ~clk;

  flash_erase_seq #(.BLK_W(BLK_W), .OFF_W(OFF_W), .WE_CYCLES(WE_CYC),
                    .READ_CYCLES(RD_CYC), .CNT_W(CNT_W)) i_flash_erase_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .blockAddr(blockAddr),
    .lastBlock(lastBlock), .checkEach(checkEach), .pollLimit(pollLimit),
    .startAck(startAck), .resultCode(resultCode), .ceN(ceN), .oeN(oeN),
    .weN(weN), .flAddr(flAddr), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural device model
  int busyPolls = 0;
  int busyLeft = 0;
  logic [7:0] errCfg = 8'h00;
  logic [7:0] sticky = 8'h00;
  logic [15:0] logAddr [16];
  logic [7:0] logData [16];
  int logN = 0;
  int readN = 0;
  int weRun = 0;
  int weBadN = 0;
  int oeGapBad = 0;
  logic prevWe = 1'b1;
  logic prevOe = 1'b1;

  always @(negedge clk) begin
    cycles++;
    if (!weN) weRun++;
    if (!prevWe && weN) begin
      if (weRun != WE_CYC) weBadN++;
      weRun = 0;
      if (logN < 16) begin
        logAddr[logN] = flAddr;
        logData[logN] = dqOut;
      end
      logN++;
      if (dqOut == 8'hD0) begin
        busyLeft = busyPolls;
        sticky = sticky | errCfg;
      end else if (dqOut == 8'h50) begin
        sticky = 8'h00;
      end
    end
    if (prevOe && !oeN) begin
      if (ceN) oeGapBad++;
      readN++;
      if (busyLeft > 0) begin
        dqIn = 8'h00;
        busyLeft--;
      end else begin
        dqIn = 8'h80 | sticky;
      end
    end
    prevWe = weN;
    prevOe = oeN;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  logic [2:0] gotCode;

  task automatic runOp(input logic [3:0] blk, input logic ce, input logic last,
                       input int busy, input logic [7:0] err);
    int waitCyc;
    busyPolls = busy;
    errCfg = err;
    logN = 0;
    readN = 0;
    @(negedge clk);
    blockAddr = blk;
    checkEach = ce;
    lastBlock = last;
    startReq = 1'b1;
    waitCyc = 0;
    while (!startAck && waitCyc < 5000) begin
      @(negedge clk);
      waitCyc++;
    end
    if (!startAck) chk(1'b0, "watchdog op", 0, 1);
    gotCode = resultCode;
    @(negedge clk);
    chk(!startAck, "R11 ack one cycle", startAck, 0);
    startReq = 1'b0;
  endtask

  task automatic chkWrites(input logic [3:0] blk, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input logic [7:0] d3, input int n);
    logic [7:0] expD [4];
    expD[0] = d0; expD[1] = d1; expD[2] = d2; expD[3] = d3;
    chk(logN == n, "R6/R7/R8 write count", logN, n);
    for (int i = 0; i < n && i < logN; i++) begin
      chk(logData[i] == expD[i], (i == 0) ? "R1 setup data" : (i == 1) ? "R2 confirm data" : "R6/R7 closing data",
          logData[i], expD[i]);
      chk(logAddr[i] == {blk, 12'h000}, "R1/R2 write address", logAddr[i], {blk, 12'h000});
    end
  endtask

  typedef struct packed {
    logic       ce;
    logic       last;
    logic [7:0] busy;
    logic [7:0] err;
    logic [2:0] code;
    logic       clr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd0, 8'h00, 3'd0, 1'b0},  // R5 clean
    '{1'b1, 1'b0, 8'd3, 8'h08, 3'd1, 1'b1},  // R5 bit3
    '{1'b1, 1'b0, 8'd1, 8'h30, 3'd2, 1'b1},  // R5 bits4+5
    '{1'b1, 1'b0, 8'd2, 8'h20, 3'd3, 1'b1},  // R5 bit5
    '{1'b1, 1'b0, 8'd0, 8'h02, 3'd4, 1'b1},  // R5 bit1
    '{1'b1, 1'b0, 8'd4, 8'h0A, 3'd1, 1'b1},  // R5 bit3 beats bit1
    '{1'b1, 1'b0, 8'd1, 8'h22, 3'd3, 1'b1},  // R5 bit5 beats bit1
    '{1'b1, 1'b0, 8'd0, 8'h10, 3'd0, 1'b0},  // R5 bit4 alone is not an error
    '{1'b0, 1'b1, 8'd5, 8'h00, 3'd0, 1'b0}   // R7 checked by last flag
  };

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(ceN && oeN && weN, "R10 strobes idle in reset", {ceN, oeN, weN}, 3'b111);
    chk(!dqOe && !startAck, "R10 no drive, no ack in reset", {dqOe, startAck}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ceN && oeN && weN && !dqOe && !startAck, "R10 idle after reset",
        {ceN, oeN, weN, dqOe, startAck}, 5'b11100);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      sticky = 8'h00;
      runOp(4'(v), VECS[v].ce, VECS[v].last, int'(VECS[v].busy), VECS[v].err);
      chk(gotCode == VECS[v].code, "R5 result code", gotCode, VECS[v].code);
      chk(readN == int'(VECS[v].busy) + 1, "R4 poll read count", readN, int'(VECS[v].busy) + 1);
      if (VECS[v].clr) chkWrites(4'(v), 8'h20, 8'hD0, 8'h50, 8'hFF, 4);
      else             chkWrites(4'(v), 8'h20, 8'hD0, 8'hFF, 8'h00, 3);
    end

    // R8: series with deferred check; error of first block shows at the end
    sticky = 8'h00;
    runOp(4'hA, 1'b0, 1'b0, 2, 8'h20);
    chk(gotCode == 3'd6, "R8 deferred code", gotCode, 6);
    chkWrites(4'hA, 8'h20, 8'hD0, 8'h00, 8'h00, 2);
    chk(readN == 3, "R8 deferred still polls", readN, 3);
    runOp(4'hB, 1'b0, 1'b1, 1, 8'h00);
    chk(gotCode == 3'd3, "R7 series final check sees sticky error", gotCode, 3);
    chkWrites(4'hB, 8'h20, 8'hD0, 8'h50, 8'hFF, 4);

    // R9: device never ready
    sticky = 8'h00;
    pollLimit = 16'd4;
    runOp(4'h3, 1'b1, 1'b0, 100, 8'h00);
    chk(gotCode == 3'd5, "R9 timeout code", gotCode, 5);
    chk(readN == 4, "R9 reads before timeout", readN, 4);
    chkWrites(4'h3, 8'h20, 8'hD0, 8'hFF, 8'h00, 3);
    pollLimit = 16'd8;

    // R3 / R4 bus timing seen by the model over the whole run
    chk(weBadN == 0, "R3 write strobe width", weBadN, 0);
    chk(oeGapBad == 0, "R4 read toggles chip enable", oeGapBad, 0);

    repeat (4) @(negedge clk);
    chk(ceN && oeN && weN && !dqOe, "R10 bus idle after ops", {ceN, oeN, weN, dqOe}, 4'b1110);
    done = 1'b1;
    finishRun();
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog global", cycles, 0);
      finishRun();
    end
  end

endmodule